// File: doc/BRIEF.md
# Bus Bridge Request Queues

This block is the internal queuing front end of a parallel external-bus bridge. Requesters talk to it through a single command port. Writes are posted into a small write queue and drained to the external bus engine later, so a writer never waits on external timing unless the queue is full. Reads come in two kinds. A blocking read holds the requester (command ready low) until the engine returns data. A non-blocking read sequence is programmed with a start address, an element size and a count. The block then walks the address range on its own and collects the results in a read queue, which the requester drains with pop commands.

Each queue drives its own DMA request line. The write-side request is high while the write queue is empty, which invites a DMA channel to refill it. The read-side request is high while the read queue holds at least a programmable number of results. The engine side is a valid/ready request channel with a separate read-data strobe. At most one engine read is outstanding at a time. A sticky flag records any non-blocking result that arrived when the read queue had no room.

Top module: `bus_bridge_queues`

## Requirements
- R1: A write command (op 0) is accepted while `cmd_ready` is high and reaches the engine unchanged, in acceptance order, with `eng_write` high and `eng_size` 2.
- R2: While the engine holds `eng_ready` low, exactly five writes are accepted: four in the queue and one held at the engine port. The next write sees `cmd_ready` low.
- R3: `dma_wr_req` is high exactly when the write queue holds no entries.
- R4: A blocking read (op 1, address on `cmd_addr`) keeps `cmd_ready` low until the engine returns its data. It is issued only after every earlier posted write has been handed to the engine. On the accepting cycle, `rsp_data` equals the returned word.
- R5: A sequence start (op 2) takes the start address from `cmd_addr`, the size code from `cmd_wdata[1:0]` and the count from `cmd_wdata[15:8]`. It issues exactly count engine reads at addresses start + i·2^size, each with `eng_size` equal to the size code. A count of zero issues none.
- R6: Sequence results are stored in arrival order. A pop (op 4) returns the oldest on `rsp_data`. A pop on an empty read queue stalls with `cmd_ready` low.
- R7: A threshold command (op 3) loads `cmd_wdata[2:0]`. `dma_rd_req` is high exactly while read-queue occupancy is at or above that value, which is 4 after reset.
- R8: A sequence result that arrives while the read queue holds 8 entries is dropped and sets `err_overflow`. The flag stays set until a clear command (op 5).
- R9: Once `eng_valid` is raised, it and the request fields hold steady until `eng_ready` is seen, and no second read is issued before the first one's data returns.
- R10: Queued writes go to the engine before any pending sequence read.
- R11: After reset both queues are empty, `dma_wr_req` is 1, `dma_rd_req` and `err_overflow` are 0, and `eng_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 3 | Command code (0 write, 1 blocking read, 2 sequence start, 3 threshold, 4 pop, 5 clear error) |
| cmd_addr | input | AW | Address for write, blocking read or sequence start |
| cmd_wdata | input | DW | Write data or command fields |
| cmd_ready | output | 1 | Command accepted on this edge when high with cmd_valid |
| rsp_data | output | DW | Read result, valid on an accepted blocking read or pop |
| dma_wr_req | output | 1 | Write-side DMA request (write queue empty) |
| dma_rd_req | output | 1 | Read-side DMA request (read queue at or above threshold) |
| err_overflow | output | 1 | Sticky dropped-result flag |
| eng_valid | output | 1 | Engine request valid |
| eng_write | output | 1 | Engine request is a write |
| eng_addr | output | AW | Engine request address |
| eng_wdata | output | DW | Engine write data |
| eng_size | output | 2 | Engine access size code (bytes = 2^code) |
| eng_ready | input | 1 | Engine accepts the request |
| eng_rvalid | input | 1 | Engine read data strobe |
| eng_rdata | input | DW | Engine read data |

## Verification
The checker watches the invariants that hold on every cycle. These are request stability at the engine port, blocking reads issued only with no queued writes, no write-queue pop while the write DMA request is high, write-queue occupancy bounds, pops only from a non-empty read queue, drops that leave occupancy unchanged, error stickiness, and rises of the read request traced to a push or a threshold load. Only the bench scenarios can show the rest. That covers address stepping for every size and count, data order through the read queue, the exact stall point of the write queue, ordering between writes and reads at the engine, and the read request level across every threshold and occupancy.

// File: rtl/bbq_pkg.sv
package bbq_pkg;

  typedef enum logic [2:0] {
    OP_WRITE   = 3'd0,
    OP_BREAD   = 3'd1,
    OP_NBSTART = 3'd2,
    OP_THRESH  = 3'd3,
    OP_POP     = 3'd4,
    OP_CLRERR  = 3'd5
  } bbq_op_e;

  typedef enum logic [1:0] {
    ARB_IDLE,
    ARB_ISSUE,
    ARB_WAIT,
    ARB_HOLD
  } bbq_arb_e;

  // byte stride for a size code
  function automatic logic [31:0] bbq_stride(input logic [1:0] size);
    return 32'd1 << size;
  endfunction

  // fill-level comparison used for the read-side DMA request
  function automatic logic bbq_level_hit(input logic [7:0] occ, input logic [7:0] thr);
    return occ >= thr;
  endfunction

  // size code of a full data word
  function automatic logic [1:0] bbq_word_size(input int dw);
    if (dw >= 64) return 2'd3;
    if (dw >= 32) return 2'd2;
    if (dw >= 16) return 2'd1;
    return 2'd0;
  endfunction

endpackage

// File: rtl/bbq_fifo.sv
module bbq_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [W-1:0]                 din,
  input  logic                         pop,
  output logic [W-1:0]                 dout,
  output logic                         full,
  output logic                         empty,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_ptr];

  function automatic logic [PW-1:0] next_ptr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= next_ptr(wr_ptr);
      if (do_pop)  rd_ptr <= next_ptr(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/bbq_nbseq.sv
module bbq_nbseq
  import bbq_pkg::*;
#(
  parameter int AW   = 32,
  parameter int CNTW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [AW-1:0]   start_addr,
  input  logic [1:0]      start_size,
  input  logic [CNTW-1:0] start_cnt,
  input  logic            take,
  output logic            want,
  output logic [AW-1:0]   cur_addr,
  output logic [1:0]      cur_size
);
  logic [CNTW-1:0] left_q;

  assign want = (left_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_q   <= '0;
      cur_addr <= '0;
      cur_size <= '0;
    end else if (start) begin
      left_q   <= start_cnt;
      cur_addr <= start_addr;
      cur_size <= start_size;
    end else if (take) begin
      left_q   <= left_q - CNTW'(1);
      cur_addr <= cur_addr + AW'(bbq_stride(cur_size));
    end
  end
endmodule

// File: rtl/bbq_arb.sv
module bbq_arb
  import bbq_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wq_empty,
  input  logic [AW-1:0] wq_addr,
  input  logic [DW-1:0] wq_data,
  input  logic          blk_req,
  input  logic [AW-1:0] blk_addr,
  input  logic          blk_ack,
  input  logic          nb_want,
  input  logic [AW-1:0] nb_addr,
  input  logic [1:0]    nb_size,
  input  logic          eng_ready,
  input  logic          eng_rvalid,
  input  logic [DW-1:0] eng_rdata,
  output logic          wq_pop,
  output logic          nb_take,
  output logic          blk_issue,
  output logic          blk_done,
  output logic [DW-1:0] blk_data,
  output logic          nb_result,
  output logic [DW-1:0] nb_data,
  output logic          eng_valid,
  output logic          eng_write,
  output logic [AW-1:0] eng_addr,
  output logic [DW-1:0] eng_wdata,
  output logic [1:0]    eng_size
);
  localparam logic [1:0] WORD_SZ = bbq_word_size(DW);

  bbq_arb_e state_q;
  logic     blk_q;
  logic     idle;

  assign idle      = (state_q == ARB_IDLE);
  assign wq_pop    = idle && !wq_empty;
  assign blk_issue = idle && wq_empty && blk_req;
  assign nb_take   = idle && wq_empty && !blk_req && nb_want;

  assign eng_valid = (state_q == ARB_ISSUE);
  assign blk_done  = (state_q == ARB_HOLD);
  assign nb_result = (state_q == ARB_WAIT) && eng_rvalid && !blk_q;
  assign nb_data   = eng_rdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ARB_IDLE;
      blk_q     <= 1'b0;
      blk_data  <= '0;
      eng_write <= 1'b0;
      eng_addr  <= '0;
      eng_wdata <= '0;
      eng_size  <= '0;
    end else begin
      case (state_q)
        ARB_IDLE: begin
          if (wq_pop) begin
            eng_write <= 1'b1;
            eng_addr  <= wq_addr;
            eng_wdata <= wq_data;
            eng_size  <= WORD_SZ;
            blk_q     <= 1'b0;
            state_q   <= ARB_ISSUE;
          end else if (blk_issue) begin
            eng_write <= 1'b0;
            eng_addr  <= blk_addr;
            eng_wdata <= '0;
            eng_size  <= WORD_SZ;
            blk_q     <= 1'b1;
            state_q   <= ARB_ISSUE;
          end else if (nb_take) begin
            eng_write <= 1'b0;
            eng_addr  <= nb_addr;
            eng_wdata <= '0;
            eng_size  <= nb_size;
            blk_q     <= 1'b0;
            state_q   <= ARB_ISSUE;
          end
        end
        ARB_ISSUE: begin
          if (eng_ready) state_q <= eng_write ? ARB_IDLE : ARB_WAIT;
        end
        ARB_WAIT: begin
          if (eng_rvalid) begin
            if (blk_q) begin
              blk_data <= eng_rdata;
              state_q  <= ARB_HOLD;
            end else begin
              state_q  <= ARB_IDLE;
            end
          end
        end
        ARB_HOLD: begin
          if (blk_ack) state_q <= ARB_IDLE;
        end
        default: state_q <= ARB_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bus_bridge_queues.sv
module bus_bridge_queues
  import bbq_pkg::*;
#(
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter int WQ_DEPTH = 4,
  parameter int RQ_DEPTH = 8,
  parameter int CNTW     = 8,
  parameter int THRW     = 3,
  parameter int THR_INIT = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_wdata,
  output logic          cmd_ready,
  output logic [DW-1:0] rsp_data,
  output logic          dma_wr_req,
  output logic          dma_rd_req,
  output logic          err_overflow,
  output logic          eng_valid,
  output logic          eng_write,
  output logic [AW-1:0] eng_addr,
  output logic [DW-1:0] eng_wdata,
  output logic [1:0]    eng_size,
  input  logic          eng_ready,
  input  logic          eng_rvalid,
  input  logic [DW-1:0] eng_rdata
);
  localparam int WCW = $clog2(WQ_DEPTH + 1);
  localparam int RCW = $clog2(RQ_DEPTH + 1);
  localparam int WQW = AW + DW;

  bbq_op_e op;
  logic    accept;

  // named internal events
  logic            wq_push, wq_pop, wq_full, wq_empty;
  logic [WCW-1:0]  wq_count;
  logic [WQW-1:0]  wq_head;
  logic            rq_push, rq_pop, rq_drop, rq_full, rq_empty;
  logic [RCW-1:0]  rq_count;
  logic [DW-1:0]   rq_head;
  logic            blk_req, blk_ack, blk_issue, blk_done;
  logic [DW-1:0]   blk_data;
  logic            nb_start, nb_take, nb_want, nb_result;
  logic [AW-1:0]   nb_addr;
  logic [1:0]      nb_size;
  logic [DW-1:0]   nb_data;
  logic            thr_write, err_clr;
  logic [THRW-1:0] thresh_q;

  assign op     = bbq_op_e'(cmd_op);
  assign accept = cmd_valid && cmd_ready;

  always_comb begin
    case (op)
      OP_WRITE:   cmd_ready = !wq_full;
      OP_BREAD:   cmd_ready = blk_done;
      OP_NBSTART: cmd_ready = !nb_want;
      OP_POP:     cmd_ready = !rq_empty;
      default:    cmd_ready = 1'b1;
    endcase
  end

  assign wq_push   = accept && (op == OP_WRITE);
  assign blk_req   = cmd_valid && (op == OP_BREAD);
  assign blk_ack   = accept && (op == OP_BREAD);
  assign nb_start  = accept && (op == OP_NBSTART);
  assign rq_pop    = accept && (op == OP_POP);
  assign thr_write = accept && (op == OP_THRESH);
  assign err_clr   = accept && (op == OP_CLRERR);
  assign rq_push   = nb_result && !rq_full;
  assign rq_drop   = nb_result && rq_full;

  assign rsp_data   = (op == OP_BREAD) ? blk_data : rq_head;
  assign dma_wr_req = wq_empty;
  assign dma_rd_req = bbq_level_hit(8'(rq_count), 8'(thresh_q));

  bbq_fifo #(.W(WQW), .DEPTH(WQ_DEPTH)) u_wq (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (wq_push),
    .din   ({cmd_addr, cmd_wdata}),
    .pop   (wq_pop),
    .dout  (wq_head),
    .full  (wq_full),
    .empty (wq_empty),
    .count (wq_count)
  );

  bbq_fifo #(.W(DW), .DEPTH(RQ_DEPTH)) u_rq (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (rq_push),
    .din   (nb_data),
    .pop   (rq_pop),
    .dout  (rq_head),
    .full  (rq_full),
    .empty (rq_empty),
    .count (rq_count)
  );

  bbq_nbseq #(.AW(AW), .CNTW(CNTW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (nb_start),
    .start_addr (cmd_addr),
    .start_size (cmd_wdata[1:0]),
    .start_cnt  (cmd_wdata[8 +: CNTW]),
    .take       (nb_take),
    .want       (nb_want),
    .cur_addr   (nb_addr),
    .cur_size   (nb_size)
  );

  bbq_arb #(.AW(AW), .DW(DW)) u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .wq_empty   (wq_empty),
    .wq_addr    (wq_head[WQW-1 -: AW]),
    .wq_data    (wq_head[DW-1:0]),
    .blk_req    (blk_req),
    .blk_addr   (cmd_addr),
    .blk_ack    (blk_ack),
    .nb_want    (nb_want),
    .nb_addr    (nb_addr),
    .nb_size    (nb_size),
    .eng_ready  (eng_ready),
    .eng_rvalid (eng_rvalid),
    .eng_rdata  (eng_rdata),
    .wq_pop     (wq_pop),
    .nb_take    (nb_take),
    .blk_issue  (blk_issue),
    .blk_done   (blk_done),
    .blk_data   (blk_data),
    .nb_result  (nb_result),
    .nb_data    (nb_data),
    .eng_valid  (eng_valid),
    .eng_write  (eng_write),
    .eng_addr   (eng_addr),
    .eng_wdata  (eng_wdata),
    .eng_size   (eng_size)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thresh_q     <= THRW'(THR_INIT);
      err_overflow <= 1'b0;
    end else begin
      if (thr_write) thresh_q <= cmd_wdata[THRW-1:0];
      if (rq_drop)      err_overflow <= 1'b1;
      else if (err_clr) err_overflow <= 1'b0;
    end
  end
endmodule

// File: rtl/bbq_checker.sv
module bbq_checker #(
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter int WQ_DEPTH = 4,
  parameter int RQ_DEPTH = 8
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          eng_valid,
  input logic                          eng_ready,
  input logic                          eng_write,
  input logic [AW-1:0]                 eng_addr,
  input logic [DW-1:0]                 eng_wdata,
  input logic                          blk_issue,
  input logic                          wq_pop,
  input logic [$clog2(WQ_DEPTH+1)-1:0] wq_count,
  input logic                          dma_wr_req,
  input logic                          dma_rd_req,
  input logic                          rq_push,
  input logic                          rq_pop,
  input logic                          rq_drop,
  input logic [$clog2(RQ_DEPTH+1)-1:0] rq_count,
  input logic                          thr_write,
  input logic                          err_overflow,
  input logic                          err_clr
);
  // R9
  eng_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_valid && !eng_ready |=> eng_valid && $stable(eng_addr) && $stable(eng_wdata) && $stable(eng_write));

  // R4
  blk_after_writes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_issue |-> wq_count == '0);

  // R1
  write_forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wq_pop |=> eng_valid && eng_write);

  // R3
  wr_req_no_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_wr_req |-> !wq_pop);

  // R2
  wq_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wq_count <= ($clog2(WQ_DEPTH+1))'(WQ_DEPTH));

  // R6
  pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rq_pop |-> rq_count != '0);

  // R8
  drop_keeps_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rq_drop && !rq_pop |=> $stable(rq_count));

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_overflow && !err_clr |=> err_overflow);

  // R8
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_overflow) |-> $past(rq_drop));

  // R7
  rd_req_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_rd_req) |-> $past(rq_push) || $past(thr_write));
endmodule

bind bus_bridge_queues bbq_checker #(
  .AW(AW), .DW(DW), .WQ_DEPTH(WQ_DEPTH), .RQ_DEPTH(RQ_DEPTH)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .eng_valid    (eng_valid),
  .eng_ready    (eng_ready),
  .eng_write    (eng_write),
  .eng_addr     (eng_addr),
  .eng_wdata    (eng_wdata),
  .blk_issue    (blk_issue),
  .wq_pop       (wq_pop),
  .wq_count     (wq_count),
  .dma_wr_req   (dma_wr_req),
  .dma_rd_req   (dma_rd_req),
  .rq_push      (rq_push),
  .rq_pop       (rq_pop),
  .rq_drop      (rq_drop),
  .rq_count     (rq_count),
  .thr_write    (thr_write),
  .err_overflow (err_overflow),
  .err_clr      (err_clr)
);

// File: tb/bus_bridge_queues_test.sv
module bus_bridge_queues_test;
  localparam logic [2:0] C_WR = 3'd0, C_BRD = 3'd1, C_NB = 3'd2, C_THR = 3'd3,
                         C_POP = 3'd4, C_CLR = 3'd5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = 3'd7;
  logic [31:0] cmd_addr = '0, cmd_wdata = '0;
  logic        cmd_ready;
  logic [31:0] rsp_data;
  logic        dma_wr_req, dma_rd_req, err_overflow;
  logic        eng_valid, eng_write;
  logic [31:0] eng_addr, eng_wdata;
  logic [1:0]  eng_size;
  logic        eng_ready = 1'b0, eng_rvalid = 1'b0;
  logic [31:0] eng_rdata = '0;

  int errors = 0, checks = 0, cyc = 0;

  always #2 clk = ~clk;

  bus_bridge_queues uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_ready(cmd_ready),
    .rsp_data(rsp_data), .dma_wr_req(dma_wr_req), .dma_rd_req(dma_rd_req),
    .err_overflow(err_overflow), .eng_valid(eng_valid), .eng_write(eng_write),
    .eng_addr(eng_addr), .eng_wdata(eng_wdata), .eng_size(eng_size),
    .eng_ready(eng_ready), .eng_rvalid(eng_rvalid), .eng_rdata(eng_rdata)
  );

  function automatic logic [31:0] model(input logic [31:0] a);
    return (a ^ 32'h5A5A_0000) + 32'd3;
  endfunction

  // engine model
  bit          eng_stall = 1'b1, eng_jitter = 1'b0;
  bit          resp_pend = 1'b0;
  int          resp_dly = 0;
  logic [31:0] resp_data = '0;
  int          log_n = 0;
  logic        log_w [64];
  logic [31:0] log_a [64];
  logic [31:0] log_d [64];
  logic [1:0]  log_s [64];

  always @(negedge clk) begin
    cyc++;
    eng_rvalid = 1'b0;
    if (resp_pend) begin
      if (resp_dly == 0) begin
        eng_rvalid = 1'b1;
        eng_rdata  = resp_data;
        resp_pend  = 1'b0;
      end else resp_dly--;
    end
    eng_ready = !eng_stall && !(eng_jitter && (cyc % 3 == 2));
    if (eng_valid && eng_ready) begin
      if (log_n < 64) begin
        log_w[log_n] = eng_write;
        log_a[log_n] = eng_addr;
        log_d[log_n] = eng_wdata;
        log_s[log_n] = eng_size;
      end
      log_n++;
      if (!eng_write) begin
        resp_pend = 1'b1;
        resp_dly  = cyc % 3;
        resp_data = model(eng_addr);
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish (actual cycles %0d, expected < 150000)", cyc);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_cmd(input logic [2:0] op, input logic [31:0] a, input logic [31:0] d,
                        input int maxw, output bit got, output logic [31:0] rd);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_wdata = d;
    got = 1'b0; rd = '0;
    for (int w = 0; w <= maxw; w++) begin
      #1;
      if (cmd_ready) begin
        got = 1'b1; rd = rsp_data;
        @(posedge clk);
        break;
      end
      @(negedge clk);
    end
    #1;
    cmd_valid = 1'b0; cmd_op = 3'd7;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  bit          g, g2;
  logic [31:0] r, r2;
  int          acc, rel_cyc, done_cyc;

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R11 reset state
    chk("R11 eng_valid", eng_valid, 0);
    chk("R11 dma_wr_req", dma_wr_req, 1);
    chk("R11 dma_rd_req", dma_rd_req, 0);
    chk("R11 err_overflow", err_overflow, 0);
    do_cmd(C_POP, 0, 0, 3, g, r);
    chk("R6 pop on empty stalls", g, 0);

    // R1 R2 R3: posted writes against a stalled engine
    eng_stall = 1; log_n = 0; acc = 0;
    for (int i = 0; i < 6; i++) begin
      do_cmd(C_WR, 32'h100 + i * 4, 32'hC0DE_0000 + i, 12, g, r);
      if (g) acc++;
    end
    chk("R2 writes accepted before stall", acc, 5);
    idle(1);
    chk("R3 dma_wr_req low with queued writes", dma_wr_req, 0);
    eng_stall = 0;
    idle(40);
    chk("R3 dma_wr_req high once drained", dma_wr_req, 1);
    chk("R1 engine transfer count", log_n, 5);
    for (int i = 0; i < 5; i++) begin
      chk("R1 write flag", log_w[i], 1);
      chk("R1 write addr", log_a[i], 32'h100 + i * 4);
      chk("R1 write data", log_d[i], 32'hC0DE_0000 + i);
      chk("R1 write size", log_s[i], 2);
    end

    // R4: blocking read behind queued writes
    eng_stall = 1; log_n = 0;
    for (int i = 0; i < 3; i++) do_cmd(C_WR, 32'h40 + i * 4, 32'hB000 + i, 12, g, r);
    fork
      begin do_cmd(C_BRD, 32'h0000_0A00, 0, 400, g2, r2); done_cyc = cyc; end
      begin idle(12); rel_cyc = cyc; eng_stall = 0; end
    join
    chk("R4 blocking read completes", g2, 1);
    chk("R4 blocking read data", r2, model(32'h0A00));
    chk("R4 held until data", (done_cyc > rel_cyc), 1);
    chk("R4 engine count", log_n, 4);
    for (int i = 0; i < 3; i++) chk("R4 writes first", log_w[i], 1);
    chk("R4 read last", log_w[3], 0);
    chk("R4 read addr", log_a[3], 32'h0A00);

    // R5 R6: sequences over sizes and counts
    eng_jitter = 1;
    for (int sz = 0; sz < 3; sz++) begin
      for (int ci = 0; ci < 4; ci++) begin
        int cnt;
        logic [31:0] base;
        cnt  = (ci == 0) ? 0 : (ci == 1) ? 1 : (ci == 2) ? 3 : 5;
        base = 32'h1000 * (sz + 1) + 32'h40;
        log_n = 0;
        do_cmd(C_NB, base, (cnt << 8) | sz, 20, g, r);
        chk("R5 start accepted", g, 1);
        idle(50);
        chk("R5 read count", log_n, cnt);
        for (int i = 0; i < cnt; i++) begin
          chk("R5 read flag", log_w[i], 0);
          chk("R5 read addr", log_a[i], base + (i << sz));
          chk("R5 read size", log_s[i], sz);
        end
        for (int i = 0; i < cnt; i++) begin
          do_cmd(C_POP, 0, 0, 5, g, r);
          chk("R6 pop order", r, model(base + (i << sz)));
        end
        do_cmd(C_POP, 0, 0, 4, g, r);
        chk("R6 pop empty stalls", g, 0);
      end
    end

    // R7: every threshold across every occupancy
    for (int t = 0; t < 8; t++) begin
      do_cmd(C_THR, 0, t, 3, g, r);
      do_cmd(C_NB, 32'h2000, (8 << 8) | 2, 20, g, r);
      idle(90);
      for (int occ = 8; occ >= 0; occ--) begin
        idle(1);
        chk("R7 read request level", dma_rd_req, (occ >= t) ? 1 : 0);
        if (occ > 0) do_cmd(C_POP, 0, 0, 5, g, r);
      end
    end

    // R8: overflow drop and sticky flag
    do_cmd(C_THR, 0, 7, 3, g, r);
    chk("R8 flag clear before", err_overflow, 0);
    do_cmd(C_NB, 32'h3000, (11 << 8) | 2, 20, g, r);
    idle(120);
    chk("R8 flag set on drop", err_overflow, 1);
    for (int i = 0; i < 8; i++) begin
      do_cmd(C_POP, 0, 0, 5, g, r);
      chk("R8 kept results", r, model(32'h3000 + i * 4));
    end
    do_cmd(C_POP, 0, 0, 4, g, r);
    chk("R8 dropped results not stored", g, 0);
    chk("R8 flag still set", err_overflow, 1);
    do_cmd(C_CLR, 0, 0, 3, g, r);
    idle(1);
    chk("R8 flag cleared", err_overflow, 0);

    // R10 R9: writes ahead of a pending sequence
    eng_stall = 1; eng_jitter = 0; log_n = 0;
    do_cmd(C_WR, 32'h500, 32'h11, 8, g, r);
    do_cmd(C_WR, 32'h504, 32'h22, 8, g, r);
    do_cmd(C_NB, 32'h600, (2 << 8) | 2, 20, g, r);
    idle(5);
    chk("R9 request held while stalled", eng_valid, 1);
    chk("R9 held request is first write", eng_addr, 32'h500);
    eng_stall = 0;
    idle(40);
    chk("R10 transfer count", log_n, 4);
    chk("R10 first write", log_w[0], 1);
    chk("R10 second write", log_w[1], 1);
    chk("R10 reads after writes", {log_w[2], log_w[3]}, 0);
    chk("R10 read addr", log_a[3], 32'h604);
    do_cmd(C_POP, 0, 0, 5, g, r);
    chk("R6 pop after mix", r, model(32'h600));
    do_cmd(C_POP, 0, 0, 5, g, r);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule